// File: doc/BRIEF.md
# Infrared SIR Pulse Codec

This block sits between a UART and an infrared transceiver and works in both directions. On the transmit side it watches the UART's serial output. For every zero bit, the start bit included, it emits one short high pulse on the infrared output. A one bit, the stop bit included, leaves the infrared output low for the whole bit. The pulse width is either three sixteenths of a bit period, measured in 16x baud ticks, or a fixed width counted in system clocks. A 3-bit select input picks between them.

On the receive side the infrared input passes through a two-stage synchroniser, and its rising edges are detected. Each detected edge pulls the UART receive line low until the 16th baud tick after that edge, which is the end of that bit period. With no edge the line stays high. A pulse of any width, however short, decodes as a zero.

Both directions share the system clock and a one-clock-wide 16x baud tick. No valid/ready handshake applies: both sides are continuous serial lines with no back-pressure, so every input is a plain level sampled on the clock.

Top module: `sir_codec`

## Requirements
- R1: A UART bit of value 0 on `utx` produces exactly one high pulse on `irtx`. The pulse rises on the clock edge of the first baud tick after `utx` took that bit value.
- R2: A UART bit of value 1 on `utx` produces no pulse: `irtx` stays low for the whole bit.
- R3: With `wsel` = 0 the pulse is 3 baud ticks long. It rises at one tick edge and falls at the third tick edge after that.
- R4: With `wsel` = k, for k from 1 to 7, the pulse is 8·(k+1) system clocks long, from 16 clocks up to 64 clocks.
- R5: `wsel` is sampled only on the clock edge where a pulse starts. Changing it while a pulse is high neither shortens nor lengthens that pulse.
- R6: A falling edge on `utx` restarts the transmit bit phase. Pulses stay correctly placed after an idle gap of any length, counted in ticks, and each further bit lasts 16 ticks.
- R7: A rising edge on `irrx` drives `urx` low on the third clock edge after `irrx` is first sampled high (two synchroniser stages and one edge stage).
- R8: `urx` returns high on the 16th baud tick after the edge that pulled it low, unless a new edge arrives first. While no edge is seen, `urx` stays high.
- R9: An `irrx` pulse only one system clock wide is still decoded as a 0 bit and is not discarded.
- R10: While `rst_n` is low, `irtx` is driven low and `urx` is driven high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | One-clock strobe at 16 times the bit rate |
| wsel | input | 3 | Pulse width select: 0 gives 3/16 of a bit, k gives 8·(k+1) clocks |
| utx | input | 1 | Serial output of the UART transmitter |
| irtx | output | 1 | Drive to the infrared emitter, high while a pulse is sent |
| irrx | input | 1 | Output of the infrared detector, high while a pulse is seen |
| urx | output | 1 | Serial input to the UART receiver |

## Verification
The transmit path is driven with whole UART frames of different byte values. Alternating bits, a run of zeros and all ones separate the pulse-per-zero rule from the silence-per-one rule. The run of zeros checks that adjacent pulses stay separate. Frames sent after idle gaps that are not a multiple of 16 ticks show whether the bit phase is realigned on the start bit. The bench measures the exact delay from each bit start to its pulse. Every width code is tried, and `wsel` is changed while a pulse is high, to show that the width is sampled only once. On receive, wide pulses, one-clock pulses and back-to-back zeros are applied. `urx` is sampled mid-bit, on the 15th tick and on the 16th tick, which pins down both the decode and the release point.

// File: rtl/sir_pkg.sv
`timescale 1ns/1ps
package sir_pkg;

  // How the running transmit pulse measures its length.
  typedef enum logic {
    WM_TICKS  = 1'b0,   // counts 16x baud ticks
    WM_CLOCKS = 1'b1    // counts system clocks
  } width_mode_e;

  // Fixed-width pulse length in system clocks for a nonzero select code.
  function automatic int fixed_clocks(input int unit, input int code);
    return unit * (code + 1);
  endfunction

endpackage

// File: rtl/sir_tx_enc.sv
`timescale 1ns/1ps
module sir_tx_enc
  import sir_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16,
  parameter int PULSE_TICKS   = 3,
  parameter int FIX_UNIT      = 8,
  parameter int SEL_W         = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [SEL_W-1:0] wsel,
  input  logic             utx,
  output logic             irtx
);

  localparam int PH_W    = $clog2(TICKS_PER_BIT);
  localparam int MAX_FIX = fixed_clocks(FIX_UNIT, (1 << SEL_W) - 1);
  localparam int MAX_LEN = (MAX_FIX > PULSE_TICKS) ? MAX_FIX : PULSE_TICKS;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(TICKS_PER_BIT - 1);

  logic              utx_q;
  logic [PH_W-1:0]   phase;
  logic [CNT_W-1:0]  remain;
  logic [CNT_W-1:0]  load_len;
  width_mode_e       mode_q;
  width_mode_e       mode_new;
  logic              fall;
  logic              launch;
  logic              step;

  assign fall   = utx_q & ~utx;
  assign launch = tick & ~fall & (phase == '0) & ~utx;
  assign step   = (mode_q == WM_CLOCKS) | tick;

  always_comb begin
    if (wsel == '0) begin
      mode_new = WM_TICKS;
      load_len = CNT_W'(PULSE_TICKS);
    end else begin
      mode_new = WM_CLOCKS;
      load_len = CNT_W'(FIX_UNIT) * (CNT_W'(wsel) + CNT_W'(1));
    end
  end

  // Bit phase: realigned by each start-bit edge, otherwise it wraps every bit.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      utx_q <= 1'b1;
      phase <= '0;
    end else begin
      utx_q <= utx;
      if (fall)
        phase <= '0;
      else if (tick)
        phase <= (phase == PH_LAST) ? '0 : phase + PH_W'(1);
    end
  end

  // Pulse generator: width and mode latched once, at launch.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irtx   <= 1'b0;
      remain <= '0;
      mode_q <= WM_TICKS;
    end else if (launch) begin
      irtx   <= 1'b1;
      remain <= load_len;
      mode_q <= mode_new;
    end else if (irtx && step) begin
      if (remain == CNT_W'(1))
        irtx <= 1'b0;
      remain <= remain - CNT_W'(1);
    end
  end

endmodule

// File: rtl/sir_rx_dec.sv
`timescale 1ns/1ps
module sir_rx_dec #(
  parameter int TICKS_PER_BIT = 16,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic irrx,
  output logic urx
);

  localparam int PH_W = $clog2(TICKS_PER_BIT);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(TICKS_PER_BIT - 1);

  // Synchroniser stages plus one history stage for the edge detector.
  logic [SYNC_STAGES:0] sync_q;
  logic                 edge_seen;
  logic                 holding;
  logic [PH_W-1:0]      ticks_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q[0] <= 1'b0;
    else        sync_q[0] <= irrx;
  end

  for (genvar g = 1; g <= SYNC_STAGES; g++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q[g] <= 1'b0;
      else        sync_q[g] <= sync_q[g-1];
    end
  end

  assign edge_seen = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      urx     <= 1'b1;
      holding <= 1'b0;
      ticks_q <= '0;
    end else if (edge_seen) begin
      urx     <= 1'b0;
      holding <= 1'b1;
      ticks_q <= '0;
    end else if (holding && tick) begin
      if (ticks_q == PH_LAST) begin
        urx     <= 1'b1;
        holding <= 1'b0;
        ticks_q <= '0;
      end else begin
        ticks_q <= ticks_q + PH_W'(1);
      end
    end
  end

endmodule

// File: rtl/sir_codec.sv
`timescale 1ns/1ps
module sir_codec #(
  parameter int TICKS_PER_BIT = 16,
  parameter int PULSE_TICKS   = 3,
  parameter int FIX_UNIT      = 8,
  parameter int SEL_W         = 3,
  parameter int SYNC_STAGES   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick16,
  input  logic [SEL_W-1:0] wsel,
  input  logic             utx,
  output logic             irtx,
  input  logic             irrx,
  output logic             urx
);

  sir_tx_enc #(
    .TICKS_PER_BIT (TICKS_PER_BIT),
    .PULSE_TICKS   (PULSE_TICKS),
    .FIX_UNIT      (FIX_UNIT),
    .SEL_W         (SEL_W)
  ) u_tx (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick16),
    .wsel  (wsel),
    .utx   (utx),
    .irtx  (irtx)
  );

  sir_rx_dec #(
    .TICKS_PER_BIT (TICKS_PER_BIT),
    .SYNC_STAGES   (SYNC_STAGES)
  ) u_rx (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick16),
    .irrx  (irrx),
    .urx   (urx)
  );

endmodule

// File: rtl/sir_codec_chk.sv
`timescale 1ns/1ps
module sir_codec_chk (
  input logic clk,
  input logic rst_n,
  input logic tick16,
  input logic utx,
  input logic irtx,
  input logic irrx,
  input logic urx
);

  // R10: outputs idle while reset is held
  p_reset_idle_r10: assert property (@(posedge clk)
    !rst_n |=> (!irtx && urx));

  // R1, R2: a pulse only starts on a tick during a zero bit
  p_pulse_from_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irtx) |-> ($past(tick16) && !$past(utx)));

  // R7: urx drops only after a fresh rising edge passed the synchroniser
  p_rx_follows_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(urx) |-> ($past(irrx, 3) && !$past(irrx, 4)));

  // R8: urx is released only on a baud tick
  p_rx_release_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(urx) |-> $past(tick16));

endmodule

bind sir_codec sir_codec_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .tick16 (tick16),
  .utx    (utx),
  .irtx   (irtx),
  .irrx   (irrx),
  .urx    (urx)
);

// File: tb/tb_sir_codec.sv
`timescale 1ns/1ps
module tb_sir_codec;

  localparam int DIV = 4;     // clocks per baud tick
  localparam int TPB = 16;    // ticks per bit
  localparam int CLK_NS = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b0;
  logic [2:0] wsel = 3'd0;
  logic       utx = 1'b1;
  logic       irrx = 1'b0;
  logic       irtx;
  logic       urx;

  int    n_cmp = 0;
  int    n_bad = 0;
  int    exp_w[$];
  string exp_tag[$];
  time   bit_t = 0;

  always #(CLK_NS/2) clk = ~clk;

  sir_codec dut (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick16 (tick16),
    .wsel   (wsel),
    .utx    (utx),
    .irtx   (irtx),
    .irrx   (irrx),
    .urx    (urx)
  );

  initial begin : tick_gen
    int c;
    c = 0;
    forever begin
      @(negedge clk);
      c++;
      tick16 = (c % DIV == 0);
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic wait_tick();
    @(posedge clk iff tick16);
    @(negedge clk);
  endtask

  function automatic int width_for(input logic [2:0] s);
    return (s == 3'd0) ? 3 * DIV : 8 * (int'(s) + 1);
  endfunction

  // Driver: one UART bit; zero bits push the expected pulse width.
  task automatic send_bit(input bit b, input string tag);
    utx = b;
    if (!b) begin
      bit_t = $time;
      exp_w.push_back(width_for(wsel));
      exp_tag.push_back(tag);
    end
    repeat (TPB) wait_tick();
  endtask

  task automatic send_frame(input logic [7:0] d, input string tag);
    send_bit(1'b0, tag);
    for (int i = 0; i < 8; i++) send_bit(d[i], tag);
    send_bit(1'b1, tag);
  endtask

  // Receive side: one infrared bit period with an optional pulse of w clocks.
  task automatic rx_bit(input bit b, input int w, input string tag);
    fork
      begin
        if (!b) begin
          irrx = 1'b1;
          repeat (w) @(negedge clk);
          irrx = 1'b0;
        end
      end
      begin
        repeat (8) wait_tick();
        check(urx == b, tag, urx, b);
        repeat (7) wait_tick();
        if (!b) check(urx == 1'b0, "R8 still low on tick 15", urx, 0);
        wait_tick();
        if (!b) check(urx == 1'b1, "R8 released on tick 16", urx, 1);
      end
    join
  endtask

  // Monitor: measures every irtx pulse and compares with the scoreboard.
  initial begin : tx_mon
    bit prev;
    int w;
    prev = 1'b0;
    w = 0;
    wait (rst_n);
    forever begin
      @(posedge clk);
      #1;
      if (irtx) begin
        if (!prev) begin
          check(tick16 == 1'b1, "R1 pulse starts on tick edge", tick16, 1);
          check(($time - bit_t) == time'(DIV*CLK_NS - 4), "R6 pulse delay from bit start",
                int'($time - bit_t), DIV*CLK_NS - 4);
        end
        w++;
      end else if (prev) begin
        if (exp_w.size() == 0) begin
          check(1'b0, "R2 pulse with no zero bit", w, 0);
        end else begin
          int e;
          string t;
          e = exp_w.pop_front();
          t = exp_tag.pop_front();
          check(w == e, t, w, e);
        end
        w = 0;
      end
      prev = irtx;
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin : main
    repeat (3) @(negedge clk);
    check(irtx == 1'b0, "R10 irtx low in reset", irtx, 0);
    check(urx == 1'b1, "R10 urx high in reset", urx, 1);
    rst_n = 1'b1;
    wait_tick();
    send_bit(1'b1, "R2 idle");
    send_bit(1'b1, "R2 idle");

    wsel = 3'd0;
    send_frame(8'hA5, "R3 3/16 width, pattern A5");
    send_frame(8'h00, "R3 3/16 width, zero run");
    send_frame(8'hFF, "R2 all ones frame");

    repeat (5) wait_tick();
    send_frame(8'h96, "R6 realign after 5-tick gap");
    repeat (11) wait_tick();
    send_frame(8'h4E, "R6 realign after 11-tick gap");

    wsel = 3'd1;
    send_frame(8'h3C, "R4 fixed width code 1");
    wsel = 3'd4;
    send_frame(8'h81, "R4 fixed width code 4");
    wsel = 3'd7;
    send_bit(1'b0, "R4 fixed width code 7");
    send_bit(1'b1, "R4 fixed width code 7");

    wsel = 3'd2;
    fork
      send_bit(1'b0, "R5 code 2 held despite change to 6");
      begin repeat (6) @(negedge clk); wsel = 3'd6; end
    join
    send_bit(1'b1, "R5");
    send_bit(1'b0, "R5 new code 6 on next pulse");
    send_bit(1'b1, "R5");
    wsel = 3'd5;
    fork
      send_bit(1'b0, "R5 code 5 held despite change to 0");
      begin repeat (6) @(negedge clk); wsel = 3'd0; end
    join
    send_bit(1'b1, "R5");
    send_bit(1'b0, "R5 back to 3/16 width");
    send_bit(1'b1, "R5");

    rx_bit(1'b1, 0, "R8 idle decodes 1");
    rx_bit(1'b0, 12, "R7 wide pulse decodes 0");
    rx_bit(1'b1, 0, "R8 no pulse decodes 1");
    rx_bit(1'b0, 1, "R9 one-clock pulse decodes 0");
    rx_bit(1'b0, 1, "R9 back-to-back short pulses");
    rx_bit(1'b0, 30, "R7 long pulse decodes 0");
    rx_bit(1'b1, 0, "R8 no pulse decodes 1");

    send_bit(1'b1, "R2 tail");
    send_bit(1'b1, "R2 tail");
    check(exp_w.size() == 0, "R1 every zero bit produced a pulse", exp_w.size(), 0);
    finish_run();
  end

endmodule